// File: doc/BRIEF.md
# MTU-limited UDP frame segmenter

This block takes one outgoing UDP payload as a byte stream and cuts it into fragments small enough for one Ethernet frame each. The size limit comes from a register. Each fragment leaves on a registered output stream. That stream marks the first and last byte of the fragment and carries the fragment's byte count, its offset in 8-byte units and a more-fragments flag. A downstream header builder uses these fields to form IPv4 fragment headers.

Transport is off after reset. Software turns it on through a small configuration write port, which also sets the maximum frame size. The limit is clamped to a legal range. A fragment limit that is not a multiple of 8 is rounded down, so that each fragment offset falls on an 8-byte boundary. A payload longer than the largest allowed size is cut at that size and the final fragment is flagged. Three counters track emitted frames, whole packets and payload bytes.

Top module: `udp_frag_segmenter`

## Requirements
- R1: After reset the transport enable is 0, the frame limit is 1400, `s_ready` and `m_valid` are low, and all three counters read 0. No byte is accepted or emitted while the enable is 0.
- R2: A write to the limit stores 4000 if the value is above 4000, stores 8 if it is below 8, and otherwise stores the value as written.
- R3: Every fragment except the last carries exactly L bytes, where L is the stored limit rounded down to a multiple of 8. The last fragment carries the remainder, from 1 to L bytes. Bytes come out in input order and unchanged.
- R4: `m_sof` is 1 on the first byte of each fragment and `m_eof` is 1 on its last byte. On the `m_eof` beat, `m_len` equals the fragment's byte count.
- R5: `m_offset` equals the fragment's starting byte position in the payload divided by 8. It stays constant over all beats of the fragment.
- R6: On the `m_eof` beat, `m_more` is 1 for every fragment except the final one of a packet, and 0 for the final one.
- R7: At most 64000 bytes of a payload are emitted. If the payload is longer, the fragment ending at byte 64000 is final and has `m_trunc`=1. The remaining input bytes are accepted and discarded up to `s_last`, and the next packet is handled normally. `m_trunc` is 0 on every other beat.
- R8: While `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and all output fields hold their values.
- R9: On each accepted `m_eof` beat, `cnt_frames` increments by 1 and `cnt_bytes` increases by `m_len`. `cnt_packets` increments only on the final fragment of a packet.
- R10: A configuration write with `cfg_sel`=0 writes the frame limit. A write with `cfg_sel`=1 writes the transport enable from `cfg_wdata` bit 0. A new limit takes effect at the next packet start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the frame limit, 1 selects the enable |
| cfg_wdata | input | 16 | Configuration write data |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | 8 | Payload byte |
| s_last | input | 1 | Last byte of the payload |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 8 | Fragment byte |
| m_sof | output | 1 | First byte of a fragment |
| m_eof | output | 1 | Last byte of a fragment |
| m_len | output | 16 | Fragment byte count, meaningful on the `m_eof` beat |
| m_offset | output | 13 | Fragment offset in 8-byte units |
| m_more | output | 1 | More fragments follow, meaningful on the `m_eof` beat |
| m_trunc | output | 1 | Payload was truncated at the size cap |
| cnt_frames | output | 32 | Emitted fragment count |
| cnt_packets | output | 32 | Emitted whole packet count |
| cnt_bytes | output | 32 | Emitted payload byte count |

## Verification
The bench programs a limit of 1003 and expects 1000-byte fragments. A design that skips the rounding would produce offsets that cannot be expressed in 8-byte units. A payload that is an exact multiple of the limit must end on a full-size fragment with the more flag clear; an off-by-one design would emit an extra empty fragment or leave the flag set. The bench writes 5000 and 3 to probe both clamp bounds, and sends a single-byte payload. A 64005-byte payload must stop at 64000 bytes with the truncation flag set, and the packet that follows must arrive intact; a design that forgets to drain the tail would merge it into that packet. Random stalls on both sides check that outputs hold under backpressure and that bytes are neither lost nor repeated.

// File: rtl/udp_frag_segmenter.sv
module udp_frag_segmenter #(
  parameter int LW          = 16,
  parameter int OW          = 13,
  parameter int CW          = 32,
  parameter int FRAME_CAP   = 4000,
  parameter int FRAME_MIN   = 8,
  parameter int FRAME_RST   = 1400,
  parameter int PAYLOAD_CAP = 64000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [LW-1:0] cfg_wdata,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [7:0]    m_data,
  output logic          m_sof,
  output logic          m_eof,
  output logic [LW-1:0] m_len,
  output logic [OW-1:0] m_offset,
  output logic          m_more,
  output logic          m_trunc,
  output logic [CW-1:0] cnt_frames,
  output logic [CW-1:0] cnt_packets,
  output logic [CW-1:0] cnt_bytes
);

  logic          en_q, in_pkt, drop;
  logic [LW-1:0] mtu_q, pkt_lim, frag_cnt, pay_cnt;
  logic [OW-1:0] off_q;

  wire [LW-1:0] lim_now = {mtu_q[LW-1:3], 3'b000};
  wire [LW-1:0] eff_lim = in_pkt ? pkt_lim : lim_now;
  wire [LW-1:0] fl      = frag_cnt + 1'b1;
  wire [LW-1:0] pl      = pay_cnt + 1'b1;
  wire          hit_pay = (pl == LW'(PAYLOAD_CAP));
  wire          fin     = s_last | hit_pay;
  wire          eof     = fin | (fl == eff_lim);

  assign s_ready = en_q & (drop | ~m_valid | m_ready);
  wire s_fire = s_valid & s_ready;
  wire load   = s_fire & ~drop;
  wire m_fire = m_valid & m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      mtu_q <= LW'(FRAME_RST);
    end else if (cfg_wr) begin
      if (cfg_sel) en_q <= cfg_wdata[0];
      else if (cfg_wdata > LW'(FRAME_CAP)) mtu_q <= LW'(FRAME_CAP);
      else if (cfg_wdata < LW'(FRAME_MIN)) mtu_q <= LW'(FRAME_MIN);
      else mtu_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      drop     <= 1'b0;
      pkt_lim  <= '0;
      frag_cnt <= '0;
      pay_cnt  <= '0;
      off_q    <= '0;
    end else if (s_fire && drop) begin
      if (s_last) drop <= 1'b0;
    end else if (load) begin
      if (!in_pkt) pkt_lim <= lim_now;
      in_pkt   <= ~fin;
      pay_cnt  <= fin ? '0 : pl;
      frag_cnt <= eof ? '0 : fl;
      if (eof) off_q <= fin ? '0 : off_q + OW'(eff_lim >> 3);
      drop     <= hit_pay & ~s_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_data   <= '0;
      m_sof    <= 1'b0;
      m_eof    <= 1'b0;
      m_len    <= '0;
      m_offset <= '0;
      m_more   <= 1'b0;
      m_trunc  <= 1'b0;
    end else if (load) begin
      m_valid  <= 1'b1;
      m_data   <= s_data;
      m_sof    <= (frag_cnt == '0);
      m_eof    <= eof;
      m_len    <= fl;
      m_offset <= off_q;
      m_more   <= ~fin;
      m_trunc  <= hit_pay & ~s_last;
    end else if (m_fire) begin
      m_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_frames  <= '0;
      cnt_packets <= '0;
      cnt_bytes   <= '0;
    end else if (m_fire && m_eof) begin
      cnt_frames <= cnt_frames + 1'b1;
      cnt_bytes  <= cnt_bytes + CW'(m_len);
      if (!m_more) cnt_packets <= cnt_packets + 1'b1;
    end
  end

  // R1
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !s_ready);

  // R2
  limit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mtu_q <= LW'(FRAME_CAP) && mtu_q >= LW'(FRAME_MIN));

  // R3
  frag_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_eof |-> m_len != '0 && m_len <= LW'(FRAME_CAP) &&
                         (!m_more || m_len[2:0] == 3'b000));

  // R5
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_fire && !m_eof |=> !m_valid || m_offset == $past(m_offset));

  // R7
  payload_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_cnt < LW'(PAYLOAD_CAP));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_eof) &&
                            $stable(m_sof) && $stable(m_len) && $stable(m_offset));

endmodule

// File: tb/tb_udp_frag_segmenter.sv
`timescale 1ns/1ps
module tb_udp_frag_segmenter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [15:0] cfg_wdata = '0;
  logic s_valid = 0, s_last = 0, m_ready = 0;
  logic [7:0] s_data = '0;
  logic s_ready, m_valid, m_sof, m_eof, m_more, m_trunc;
  logic [7:0] m_data;
  logic [15:0] m_len;
  logic [12:0] m_offset;
  logic [31:0] cnt_frames, cnt_packets, cnt_bytes;

  int checks = 0, errors = 0;
  int mtu_b = 1400;
  longint tot_fr = 0, tot_pk = 0, tot_by = 0;

  always #2.5 clk = ~clk;

  udp_frag_segmenter dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 13 + (i >> 8) + 5);
  endfunction

  task automatic cfg(input bit sel, input int v);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = 16'(v);
    @(negedge clk);
    cfg_wr = 0;
    if (!sel) mtu_b = v > 4000 ? 4000 : (v < 8 ? 8 : v);
  endtask

  task automatic send(input int n, input bit bp);
    int lim = mtu_b - mtu_b % 8;
    int nout = n > 64000 ? 64000 : n;
    int nfr = (nout + lim - 1) / lim;
    int idx = 0, k = 0, cyc = 0, frs = 0;
    int bad_d = 0, bad_sof = 0, bad_off = 0, bad_stab = 0, bad_tr = 0;
    bit held = 0;
    logic [7:0] h_d; logic h_e; logic [12:0] h_o;
    while ((idx < n || k < nout) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      s_valid = (idx < n) && !(bp && cyc % 5 == 0);
      s_data  = pat(idx);
      s_last  = (idx == n - 1);
      m_ready = !bp || (cyc % 3 != 0);
      #1;
      if (held && (!m_valid || m_data != h_d || m_eof != h_e || m_offset != h_o)) bad_stab++;
      held = 0;
      if (m_valid && !m_ready) begin held = 1; h_d = m_data; h_e = m_eof; h_o = m_offset; end
      if (s_valid && s_ready) idx++;
      if (m_valid && m_ready) begin
        int w = k % lim;
        bit last = (k == nout - 1);
        bit xe = (w == lim - 1) || last;
        if (m_data != pat(k)) bad_d++;
        if (m_sof != (w == 0) || m_eof != xe) bad_sof++;
        if (m_offset != 13'((k / lim) * lim / 8)) bad_off++;
        if (m_trunc && !(xe && last && n > 64000)) bad_tr++;
        if (xe) begin
          frs++;
          chk(m_len == 16'(w + 1), "R3", "fragment length", m_len, w + 1);
          chk(m_more == !last, "R6", "more flag", m_more, !last);
          chk(m_trunc == (last && n > 64000), "R7", "trunc flag", m_trunc, last && n > 64000);
        end
        k++;
      end
    end
    @(negedge clk);
    s_valid = 0; s_last = 0; m_ready = 1;
    @(negedge clk);
    tot_fr += nfr; tot_pk++; tot_by += nout;
    chk(k == nout && idx == n, "R3", "bytes emitted", k, nout);
    chk(frs == nfr, "R3", "fragment count", frs, nfr);
    chk(bad_d == 0, "R3", "data mismatches", bad_d, 0);
    chk(bad_sof == 0, "R4", "sof/eof mismatches", bad_sof, 0);
    chk(bad_off == 0, "R5", "offset mismatches", bad_off, 0);
    chk(bad_stab == 0, "R8", "unstable held beats", bad_stab, 0);
    chk(bad_tr == 0, "R7", "stray trunc beats", bad_tr, 0);
    chk(cnt_frames == 32'(tot_fr), "R9", "frame counter", cnt_frames, tot_fr);
    chk(cnt_packets == 32'(tot_pk), "R9", "packet counter", cnt_packets, tot_pk);
    chk(cnt_bytes == 32'(tot_by), "R9", "byte counter", cnt_bytes, tot_by);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!s_ready && !m_valid, "R1", "ready/valid after reset", {s_ready, m_valid}, 0);
    chk(cnt_frames == 0 && cnt_packets == 0 && cnt_bytes == 0, "R1", "counters after reset",
        cnt_frames + cnt_packets + cnt_bytes, 0);
  endtask

  task automatic t_disabled();
    int bad = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      s_valid = 1; s_data = 8'hAA; s_last = 1; m_ready = 1;
      #1;
      if (s_ready || m_valid) bad++;
    end
    s_valid = 0; s_last = 0;
    chk(bad == 0, "R1", "activity while disabled", bad, 0);
    cfg(1'b0, 1400);
    @(negedge clk);
    chk(!s_ready, "R10", "limit write leaves enable off", s_ready, 0);
    cfg(1'b1, 1);
    @(negedge clk);
    chk(s_ready, "R10", "enable write sets ready", s_ready, 1);
    chk(cnt_frames == 0, "R1", "no frames while disabled", cnt_frames, 0);
  endtask

  task automatic t_default_limit(); send(3000, 0); endtask
  task automatic t_odd_limit();     cfg(1'b0, 1003); send(2500, 1); endtask
  task automatic t_exact_fit();     send(2000, 0); endtask
  task automatic t_single_byte();   send(1, 1); endtask
  task automatic t_clamp_high();    cfg(1'b0, 5000); send(4100, 0); endtask
  task automatic t_clamp_low();     cfg(1'b0, 3); send(20, 1); endtask
  task automatic t_truncate();      cfg(1'b0, 4000); send(64005, 0); send(10, 0); endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_default_limit();
    t_odd_limit();
    t_exact_fit();
    t_single_byte();
    t_clamp_high();
    t_clamp_low();
    t_truncate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule